// File: doc/BRIEF.md
# Multi-Operand Prefix-Sum Unit

This block is a shared functional unit that lets many thread units perform atomic fetch-and-add operations on a small bank of base registers. Each requester presents a base index and a small non-negative increment, then holds that request until it is acknowledged. In any cycle the unit picks one base that has waiting requests and combines up to `GRP` of the requests aimed at it into a single multi-operand operation. That operation finishes in one cycle. Each granted requester receives the value the base held just before its own increment was applied, and the base takes the original value plus the sum of all granted increments.

Within a group, the running values are handed out in ascending requester index, so the results are deterministic. Correct software may not rely on any particular ordering. Requests that are not granted stay pending and compete again in the next cycle. A rotating base pointer and a rotating requester pointer make sure that no waiting request is passed over indefinitely. A simple register-file port lets the base registers be loaded and read directly.

Top module: `psum_unit`

## Requirements
- R1: After reset every base register reads 0, no `req_ack` bit is high while `req_valid` is 0, and every `rsp_valid` bit is 0.
- R2: A lone granted request on base b with increment d returns the value b held before the grant, and b then reads old+d.
- R3: The granted requests of one group all target the same base. Requester i receives the base value plus the sum of the increments of the granted requesters with a lower index than i.
- R4: After a group, the base reads its original value plus the sum of all granted increments, modulo 2^32.
- R5: At most `GRP` (default 4) requests are acknowledged in a cycle, and `req_ack[i]` is only ever high while `req_valid[i]` is high. Requests that are not acknowledged wait and are reconsidered in the following cycle.
- R6: Requester selection scans the indices cyclically. The scan starts one past the last requester granted in the previous group, so with all 8 requesters pending on one base and `GRP`=4, every requester is granted within 2 cycles.
- R7: Base selection scans the base indices cyclically. The scan starts one past the base served last, so each pending base is served within `NBASE` cycles.
- R8: `rsp_valid[i]` is high in exactly the cycle after the cycle in which `req_ack[i]` was high, and `rsp_value[i*32 +: 32]` carries the returned value.
- R9: A cycle with `wr_en` high loads `wr_data` into base `wr_idx` and acknowledges no request. `rd_data` shows base `rd_idx` combinationally.
- R10: A granted request with increment 0 returns the current running value and does not change the base.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | NREQ | Request pending, held until acknowledged |
| req_base | input | NREQ*BIDX_W | Base index per requester, packed by requester |
| req_inc | input | NREQ*INC_W | Unsigned increment per requester |
| req_ack | output | NREQ | Request granted in this cycle |
| rsp_valid | output | NREQ | Response valid, one cycle after the grant |
| rsp_value | output | NREQ*32 | Returned running value per requester |
| wr_en | input | 1 | Direct load of a base register |
| wr_idx | input | BIDX_W | Base register to load |
| wr_data | input | 32 | Load value |
| rd_idx | input | BIDX_W | Base register to view |
| rd_data | output | 32 | Current value of base `rd_idx` |

## Verification
The assertions assume that every requester keeps `req_valid`, `req_base` and `req_inc` stable until it sees `req_ack`, and that every base index is below `NBASE`. Under that assumption, a grant always matches a live request and a response always follows its grant. The stimulus changes inputs only at falling edges and clears a requester's valid bit only after the grant the bench model predicts. It uses only base indices 0 to 3. It holds `req_valid` low throughout reset, so no grant can be reported during reset.

// File: rtl/psu_pkg.sv
package psu_pkg;
  localparam int PSU_W = 32;
  typedef logic [PSU_W-1:0] word_t;

  // cyclic index: (v mod n) for 0 <= v < 2n
  function automatic int psu_wrap(input int v, input int n);
    return (v >= n) ? v - n : v;
  endfunction

  // one link of the running-sum chain; wraps at 2^PSU_W
  function automatic word_t psu_bump(input word_t acc, input word_t inc, input logic take);
    return take ? acc + inc : acc;
  endfunction
endpackage

// File: rtl/psu_arbiter.sv
module psu_arbiter import psu_pkg::*; #(
  parameter int NREQ   = 8,
  parameter int NBASE  = 4,
  parameter int GRP    = 4,
  parameter int BIDX_W = 2,
  localparam int RPTR_W = (NREQ > 1) ? $clog2(NREQ) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NREQ-1:0]          req_valid,
  input  logic [NREQ*BIDX_W-1:0]   req_base,
  input  logic                     hold,
  output logic [NREQ-1:0]          grant,
  output logic                     fire,
  output logic [BIDX_W-1:0]        pick
);
  logic [BIDX_W-1:0] bptr;
  logic [RPTR_W-1:0] rptr;
  logic [NBASE-1:0]  pend;
  logic              found;
  logic [NREQ-1:0]   cand;
  logic [RPTR_W-1:0] nxt_rptr;

  // bases with at least one waiting request
  always_comb begin
    pend = '0;
    for (int i = 0; i < NREQ; i++) begin
      for (int b = 0; b < NBASE; b++) begin
        if (req_valid[i] && req_base[i*BIDX_W +: BIDX_W] == BIDX_W'(b)) pend[b] = 1'b1;
      end
    end
  end

  // cyclic base choice starting at bptr
  always_comb begin
    int b;
    found = 1'b0;
    pick  = '0;
    for (int j = 0; j < NBASE; j++) begin
      b = psu_wrap(int'(bptr) + j, NBASE);
      if (!found && pend[b]) begin
        found = 1'b1;
        pick  = BIDX_W'(b);
      end
    end
  end

  // up to GRP requesters on the chosen base, scanning from rptr
  always_comb begin
    int idx;
    int cnt;
    int last;
    cand = '0;
    cnt  = 0;
    last = int'(rptr) + NREQ - 1;
    last = psu_wrap(last, NREQ);
    for (int j = 0; j < NREQ; j++) begin
      idx = psu_wrap(int'(rptr) + j, NREQ);
      if (req_valid[idx] && req_base[idx*BIDX_W +: BIDX_W] == pick && cnt < GRP) begin
        cand[idx] = 1'b1;
        cnt  = cnt + 1;
        last = idx;
      end
    end
    nxt_rptr = RPTR_W'(psu_wrap(last + 1, NREQ));
  end

  assign fire  = found & ~hold;
  assign grant = fire ? cand : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bptr <= '0;
      rptr <= '0;
    end else if (fire) begin
      bptr <= BIDX_W'(psu_wrap(int'(pick) + 1, NBASE));
      rptr <= nxt_rptr;
    end
  end
endmodule

// File: rtl/psu_scan.sv
module psu_scan import psu_pkg::*; #(
  parameter int NREQ  = 8,
  parameter int INC_W = 2
) (
  input  logic [NREQ-1:0]        grant,
  input  logic [NREQ*INC_W-1:0]  req_inc,
  input  word_t                  base_old,
  output logic [NREQ*PSU_W-1:0]  run_val,
  output word_t                  total
);
  word_t chain [NREQ+1];

  assign chain[0] = base_old;

  // running sum in ascending requester index
  for (genvar i = 0; i < NREQ; i++) begin : g_link
    assign run_val[i*PSU_W +: PSU_W] = chain[i];
    assign chain[i+1] = psu_bump(chain[i], word_t'(req_inc[i*INC_W +: INC_W]), grant[i]);
  end

  assign total = chain[NREQ];
endmodule

// File: rtl/psu_bank.sv
module psu_bank import psu_pkg::*; #(
  parameter int NBASE  = 4,
  parameter int BIDX_W = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [BIDX_W-1:0]        wr_idx,
  input  word_t                    wr_data,
  input  logic                     upd_en,
  input  logic [BIDX_W-1:0]        upd_idx,
  input  word_t                    upd_val,
  input  logic [BIDX_W-1:0]        rd_idx,
  output word_t                    rd_data,
  input  logic [BIDX_W-1:0]        grp_idx,
  output word_t                    grp_old,
  output logic [NBASE*PSU_W-1:0]   bank_flat
);
  for (genvar g = 0; g < NBASE; g++) begin : g_reg
    word_t r;
    always_ff @(posedge clk) begin
      if (!rst_n) r <= '0;
      else if (wr_en && wr_idx == BIDX_W'(g)) r <= wr_data;
      else if (upd_en && upd_idx == BIDX_W'(g)) r <= upd_val;
    end
    assign bank_flat[g*PSU_W +: PSU_W] = r;
  end

  always_comb begin
    rd_data = '0;
    grp_old = '0;
    for (int b = 0; b < NBASE; b++) begin
      if (rd_idx == BIDX_W'(b))  rd_data = bank_flat[b*PSU_W +: PSU_W];
      if (grp_idx == BIDX_W'(b)) grp_old = bank_flat[b*PSU_W +: PSU_W];
    end
  end
endmodule

// File: rtl/psum_unit.sv
module psum_unit import psu_pkg::*; #(
  parameter int NREQ  = 8,
  parameter int NBASE = 4,
  parameter int GRP   = 4,
  parameter int INC_W = 2,
  localparam int BIDX_W = (NBASE > 1) ? $clog2(NBASE) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NREQ-1:0]          req_valid,
  input  logic [NREQ*BIDX_W-1:0]   req_base,
  input  logic [NREQ*INC_W-1:0]    req_inc,
  output logic [NREQ-1:0]          req_ack,
  output logic [NREQ-1:0]          rsp_valid,
  output logic [NREQ*PSU_W-1:0]    rsp_value,
  input  logic                     wr_en,
  input  logic [BIDX_W-1:0]        wr_idx,
  input  logic [PSU_W-1:0]         wr_data,
  input  logic [BIDX_W-1:0]        rd_idx,
  output logic [PSU_W-1:0]         rd_data
);
  // named internal events, observed by the bound checker
  logic [NREQ-1:0]          grp_grant;
  logic                     grp_fire;
  logic [BIDX_W-1:0]        grp_base;
  word_t                    grp_old;
  word_t                    grp_total;
  logic [NREQ*PSU_W-1:0]    grp_run;
  logic [NBASE*PSU_W-1:0]   bank_flat;

  psu_arbiter #(.NREQ(NREQ), .NBASE(NBASE), .GRP(GRP), .BIDX_W(BIDX_W)) arb_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_base(req_base),
    .hold(wr_en), .grant(grp_grant), .fire(grp_fire), .pick(grp_base));

  psu_bank #(.NBASE(NBASE), .BIDX_W(BIDX_W)) bank_i (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .upd_en(grp_fire), .upd_idx(grp_base), .upd_val(grp_total),
    .rd_idx(rd_idx), .rd_data(rd_data),
    .grp_idx(grp_base), .grp_old(grp_old), .bank_flat(bank_flat));

  psu_scan #(.NREQ(NREQ), .INC_W(INC_W)) scan_i (
    .grant(grp_grant), .req_inc(req_inc), .base_old(grp_old),
    .run_val(grp_run), .total(grp_total));

  assign req_ack = grp_grant;

  for (genvar i = 0; i < NREQ; i++) begin : g_rsp
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        rsp_valid[i] <= 1'b0;
        rsp_value[i*PSU_W +: PSU_W] <= '0;
      end else begin
        rsp_valid[i] <= grp_grant[i];
        if (grp_grant[i]) rsp_value[i*PSU_W +: PSU_W] <= grp_run[i*PSU_W +: PSU_W];
      end
    end
  end
endmodule

// File: rtl/psum_unit_chk.sv
module psum_unit_chk #(
  parameter int NREQ   = 8,
  parameter int NBASE  = 4,
  parameter int GRP    = 4,
  parameter int BIDX_W = 2,
  parameter int W      = 32
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [NREQ-1:0]        req_valid,
  input logic [NREQ*BIDX_W-1:0] req_base,
  input logic [NREQ-1:0]        req_ack,
  input logic [NREQ-1:0]        rsp_valid,
  input logic                   wr_en,
  input logic                   grp_fire,
  input logic [BIDX_W-1:0]      grp_base,
  input logic [W-1:0]           grp_total,
  input logic [NBASE*W-1:0]     bank_flat
);
  logic              last_fire;
  logic [BIDX_W-1:0] last_base;
  logic [W-1:0]      last_total;
  logic [NREQ-1:0]   last_ack;
  logic              off_base;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      last_fire  <= 1'b0;
      last_base  <= '0;
      last_total <= '0;
      last_ack   <= '0;
    end else begin
      last_fire  <= grp_fire;
      last_base  <= grp_base;
      last_total <= grp_total;
      last_ack   <= req_ack;
    end
  end

  always_comb begin
    off_base = 1'b0;
    for (int i = 0; i < NREQ; i++)
      if (req_ack[i] && req_base[i*BIDX_W +: BIDX_W] != grp_base) off_base = 1'b1;
  end

  a_r5_group_limit: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(req_ack) <= GRP);

  a_r5_ack_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ack & ~req_valid) == '0);

  a_r3_one_base: assert property (@(posedge clk) disable iff (!rst_n)
    !off_base);

  a_r9_write_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> req_ack == '0);

  a_r8_rsp_follows_ack: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid == last_ack);

  a_r4_base_takes_total: assert property (@(posedge clk) disable iff (!rst_n)
    last_fire |-> bank_flat[last_base*W +: W] == last_total);
endmodule

bind psum_unit psum_unit_chk #(
  .NREQ(NREQ), .NBASE(NBASE), .GRP(GRP), .BIDX_W(BIDX_W), .W(psu_pkg::PSU_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_base(req_base),
  .req_ack(req_ack), .rsp_valid(rsp_valid), .wr_en(wr_en),
  .grp_fire(grp_fire), .grp_base(grp_base), .grp_total(grp_total),
  .bank_flat(bank_flat));

// File: tb/psum_unit_tb_top.sv
module psum_unit_tb_top;
  localparam int N  = 8;
  localparam int NB = 4;
  localparam int K  = 4;
  localparam int IW = 2;
  localparam int BW = 2;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [N-1:0]      req_valid;
  logic [N*BW-1:0]   req_base;
  logic [N*IW-1:0]   req_inc;
  logic [N-1:0]      req_ack;
  logic [N-1:0]      rsp_valid;
  logic [N*32-1:0]   rsp_value;
  logic              wr_en;
  logic [BW-1:0]     wr_idx;
  logic [31:0]       wr_data;
  logic [BW-1:0]     rd_idx;
  logic [31:0]       rd_data;

  always #2.5 clk = ~clk;

  psum_unit #(.NREQ(N), .NBASE(NB), .GRP(K), .INC_W(IW)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_base(req_base),
    .req_inc(req_inc), .req_ack(req_ack), .rsp_valid(rsp_valid),
    .rsp_value(rsp_value), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .rd_idx(rd_idx), .rd_data(rd_data));

  int checks = 0;
  int errors = 0;

  // bench-side model of the unit
  logic [31:0] m_base [NB];
  int          m_bptr, m_rptr;
  logic [N-1:0] d_v;
  int          d_b [N];
  int          d_i [N];
  logic [N-1:0] e_ack;
  logic [31:0] e_val [N];
  int          cyc_used;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // expected grant set and values from the requirements (R3, R5, R6, R7, R9)
  task automatic model_eval(input bit wr);
    int tb;
    int n;
    logic [31:0] run;
    e_ack = '0;
    tb = -1;
    if (!wr) begin
      for (int d = NB - 1; d >= 0; d--) begin
        int b = (m_bptr + d) % NB;
        for (int i = 0; i < N; i++) if (d_v[i] && d_b[i] == b) tb = b;
      end
    end
    if (tb >= 0) begin
      n = 0;
      for (int s = 0; s < N; s++) begin
        int r = (m_rptr + s) % N;
        if (n < K && d_v[r] && d_b[r] == tb) begin
          e_ack[r] = 1'b1;
          n++;
        end
      end
      run = m_base[tb];
      for (int i = 0; i < N; i++) begin
        e_val[i] = run;
        if (e_ack[i]) run = run + 32'(d_i[i]);
      end
      for (int s = N - 1; s >= 0; s--) begin
        int r = (m_rptr + s) % N;
        if (e_ack[r]) begin m_rptr = (r + 1) % N; break; end
      end
      m_base[tb] = run;
      m_bptr = (tb + 1) % NB;
    end
  endtask

  task automatic drive();
    req_valid = d_v;
    for (int i = 0; i < N; i++) begin
      req_base[i*BW +: BW] = BW'(d_b[i]);
      req_inc[i*IW +: IW]  = IW'(d_i[i]);
    end
  endtask

  // one cycle of requests; starts and ends just after a falling edge
  task automatic step(input string req, input bit wr = 1'b0,
                      input int widx = 0, input logic [31:0] wdat = 0);
    drive();
    wr_en = wr; wr_idx = BW'(widx); wr_data = wdat;
    #0.5;
    model_eval(wr);
    if (wr) m_base[widx] = wdat;
    chk(req_ack == e_ack, req, "req_ack", 32'(req_ack), 32'(e_ack));
    @(posedge clk); #0.5;
    chk(rsp_valid == e_ack, "R8", "rsp_valid", 32'(rsp_valid), 32'(e_ack));
    for (int i = 0; i < N; i++)
      if (e_ack[i])
        chk(rsp_value[i*32 +: 32] == e_val[i], req, $sformatf("rsp_value[%0d]", i),
            rsp_value[i*32 +: 32], e_val[i]);
    @(negedge clk);
    wr_en = 1'b0;
    d_v = d_v & ~e_ack;
    cyc_used++;
  endtask

  task automatic drain(input string req);
    cyc_used = 0;
    while (d_v != '0 && cyc_used < 50) step(req);
  endtask

  task automatic check_base(input int b, input logic [31:0] exp, input string req);
    rd_idx = BW'(b);
    #0.5;
    chk(rd_data == exp, req, $sformatf("base %0d", b), rd_data, exp);
  endtask

  task automatic set_req(input int i, input int b, input int inc);
    d_v[i] = 1'b1; d_b[i] = b; d_i[i] = inc;
  endtask

  task automatic t_reset();
    chk(req_ack == '0, "R1", "ack after reset", 32'(req_ack), 0);
    chk(rsp_valid == '0, "R1", "rsp_valid after reset", 32'(rsp_valid), 0);
    for (int b = 0; b < NB; b++) check_base(b, 0, "R1");
  endtask

  task automatic t_single();
    d_v = '0;
    step("R9", 1'b1, 2, 32'd100);
    check_base(2, 32'd100, "R9");
    set_req(3, 2, 1);
    step("R2");
    chk(e_val[3] == 32'd100, "R2", "model value", e_val[3], 32'd100);
    check_base(2, 32'd101, "R2");
  endtask

  task automatic t_group();
    d_v = '0;
    step("R9", 1'b1, 1, 32'd10);
    set_req(0, 1, 1); set_req(2, 1, 2); set_req(5, 1, 3); set_req(7, 1, 1);
    step("R3");
    chk(rsp_value[7*32 +: 32] == 32'd16, "R3", "last in group", rsp_value[7*32 +: 32], 32'd16);
    check_base(1, 32'd17, "R4");
  endtask

  task automatic t_overflow();
    d_v = '0;
    for (int i = 0; i < 6; i++) set_req(i, 0, 1);
    drain("R5");
    chk(cyc_used == 2, "R5", "cycles for 6 requests", 32'(cyc_used), 2);
    check_base(0, 32'd6, "R5");
  endtask

  task automatic t_wrap();
    d_v = '0;
    step("R9", 1'b1, 3, 32'hFFFF_FFFF);
    set_req(1, 3, 1); set_req(4, 3, 2);
    step("R4");
    chk(rsp_value[4*32 +: 32] == 32'd0, "R4", "wrapped value", rsp_value[4*32 +: 32], 32'd0);
    check_base(3, 32'd2, "R4");
  endtask

  task automatic t_multibase();
    d_v = '0;
    set_req(0, 0, 1); set_req(1, 0, 2); set_req(2, 1, 1);
    set_req(3, 1, 3); set_req(6, 3, 1);
    drain("R7");
    chk(cyc_used == 3, "R7", "cycles for 3 bases", 32'(cyc_used), 3);
    check_base(0, 32'd9, "R7");
    check_base(1, 32'd21, "R7");
    check_base(3, 32'd3, "R7");
  endtask

  task automatic t_zero();
    d_v = '0;
    set_req(5, 2, 0);
    step("R10");
    check_base(2, 32'd101, "R10");
    chk(e_val[5] == 32'd101, "R10", "model value", e_val[5], 32'd101);
  endtask

  task automatic t_write_block();
    d_v = '0;
    set_req(2, 0, 3);
    step("R9", 1'b1, 0, 32'd50);
    chk(d_v[2] == 1'b1, "R9", "request still pending", 32'(d_v[2]), 1);
    check_base(0, 32'd50, "R9");
    step("R9");
    check_base(0, 32'd53, "R9");
  endtask

  task automatic t_fair();
    d_v = '0;
    for (int i = 0; i < N; i++) set_req(i, 2, 1);
    drain("R6");
    chk(cyc_used == 2, "R6", "cycles for 8 requests", 32'(cyc_used), 2);
    check_base(2, 32'd109, "R6");
    for (int i = 0; i < N; i++) set_req(i, 2, 1);
    drain("R6");
    chk(cyc_used == 2, "R6", "second round cycles", 32'(cyc_used), 2);
    check_base(2, 32'd117, "R6");
  endtask

  initial begin
    for (int b = 0; b < NB; b++) m_base[b] = '0;
    m_bptr = 0; m_rptr = 0;
    d_v = '0;
    for (int i = 0; i < N; i++) begin d_b[i] = 0; d_i[i] = 0; end
    req_valid = '0; req_base = '0; req_inc = '0;
    wr_en = 1'b0; wr_idx = '0; wr_data = '0; rd_idx = '0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    @(negedge clk);
    t_reset();
    t_single();
    t_group();
    t_overflow();
    t_wrap();
    t_multibase();
    t_zero();
    t_write_block();
    t_fair();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule